// File: doc/BRIEF.md
# Ethernet Receive Error Statistics

This block keeps three wrapping event counters for an Ethernet receive path. The first counts frames with a bad CRC. The second counts frames that end on a partial byte (dribbling bits, an alignment error). The third counts frames thrown away because no receive buffer was free or the receive FIFO overran.

The receive path delivers one end-of-frame strobe per frame, together with five status flags. On that strobe each counter applies its own qualification rule to the flags on its own, and increments if the rule is met.

Software can preset any counter through a small write port, but only while the channel is disabled. Any counter can be read at any time through a combinational read port.

Top module: `rx_err_stats`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) clears all three counters to zero.
- R2: On `frame_end`, the CRC counter increments when `crc_bad` is set and `addr_hit` is set, and none of `no_buf`, `overrun` or `dribble` is set.
- R3: On `frame_end`, the alignment counter increments when `dribble` and `addr_hit` are set, and neither `no_buf` nor `overrun` is set. The CRC flag has no bearing on this counter.
- R4: On `frame_end`, the discard counter increments when `no_buf` or `overrun` is set. This holds whatever the state of `crc_bad`, `addr_hit` and `dribble`.
- R5: The status flags have no effect on any counter in a cycle where `frame_end` is low.
- R6: With `chan_en` low, a cycle with `wr_en` high loads `wr_data` into the counter chosen by `wr_sel`. The selector encoding is 0 for CRC, 1 for alignment and 2 for discard. Selector 3 loads nothing.
- R7: With `chan_en` high, `wr_en` is ignored and all counters keep their values.
- R8: Every counter is `CW` bits wide and wraps modulo 2^CW, so all-ones plus one gives zero.
- R9: `rd_data` shows, in the same cycle, the counter chosen by `rd_sel` using the encoding of R6. Selector 3 reads as zero.
- R10: When an accepted write and a qualifying frame hit the same counter in the same cycle, the written value is kept and the increment is lost. Increments to the other counters still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chan_en | input | 1 | Receive channel enabled; blocks writes when high |
| frame_end | input | 1 | One-cycle strobe marking the end of a frame; the flags are sampled here |
| addr_hit | input | 1 | The frame's destination address was accepted |
| no_buf | input | 1 | The frame arrived while no buffer was free |
| overrun | input | 1 | Receive overrun occurred during the frame |
| crc_bad | input | 1 | The frame check sequence failed |
| dribble | input | 1 | The frame ended with extra bits beyond a byte boundary |
| wr_en | input | 1 | Counter preset strobe |
| wr_sel | input | 2 | Counter chosen for the preset |
| wr_data | input | CW | Preset value |
| rd_sel | input | 2 | Counter chosen for reading |
| rd_data | output | CW | Value of the chosen counter |

## Verification
The bench builds the block with the default `CW` of 32, which is the full width a real deployment uses. Wraparound is still cheap to reach: a preset of all-ones followed by one qualifying frame shows the modulo behaviour, with no need for billions of events. A table of twelve flag combinations covers every exclusion of each rule, including frames that carry every flag at once. Directed cases then cover the write lockout, collisions between a write and an increment, and the unused selector value.

// File: rtl/rx_err_stats.sv
module rx_err_stats #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          frame_end,
  input  logic          addr_hit,
  input  logic          no_buf,
  input  logic          overrun,
  input  logic          crc_bad,
  input  logic          dribble,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    rd_sel,
  output logic [CW-1:0] rd_data
);
  localparam logic [1:0] SEL_CRC = 2'd0;
  localparam logic [1:0] SEL_ALN = 2'd1;
  localparam logic [1:0] SEL_DSC = 2'd2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_crc, cnt_aln, cnt_dsc;

  wire lost    = no_buf | overrun;
  wire wr_ok   = wr_en & ~chan_en;
  wire inc_crc = frame_end & addr_hit & ~lost & ~dribble & crc_bad;
  wire inc_aln = frame_end & addr_hit & ~lost & dribble;
  wire inc_dsc = frame_end & lost;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_crc <= '0;
      cnt_aln <= '0;
      cnt_dsc <= '0;
    end else begin
      if (wr_ok && wr_sel == SEL_CRC) cnt_crc <= wr_data;
      else if (inc_crc)               cnt_crc <= cnt_crc + ONE;
      if (wr_ok && wr_sel == SEL_ALN) cnt_aln <= wr_data;
      else if (inc_aln)               cnt_aln <= cnt_aln + ONE;
      if (wr_ok && wr_sel == SEL_DSC) cnt_dsc <= wr_data;
      else if (inc_dsc)               cnt_dsc <= cnt_dsc + ONE;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_CRC: rd_data = cnt_crc;
      SEL_ALN: rd_data = cnt_aln;
      SEL_DSC: rd_data = cnt_dsc;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          frame_end,
  input logic          addr_hit,
  input logic          no_buf,
  input logic          overrun,
  input logic          crc_bad,
  input logic          dribble,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [1:0]    rd_sel,
  input logic [CW-1:0] rd_data,
  input logic [CW-1:0] cnt_crc,
  input logic [CW-1:0] cnt_aln,
  input logic [CW-1:0] cnt_dsc
);
  logic w0, w1, w2, q_crc, q_aln, q_dsc;
  assign w0 = wr_en && !chan_en && wr_sel == 2'd0;
  assign w1 = wr_en && !chan_en && wr_sel == 2'd1;
  assign w2 = wr_en && !chan_en && wr_sel == 2'd2;
  assign q_crc = frame_end && crc_bad && addr_hit && !no_buf && !overrun && !dribble;
  assign q_aln = frame_end && dribble && addr_hit && !no_buf && !overrun;
  assign q_dsc = frame_end && (no_buf || overrun);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt_crc == '0 && cnt_aln == '0 && cnt_dsc == '0));

  p_crc_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_crc && !w0) |=> cnt_crc == $past(cnt_crc) + CW'(1));
  p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_crc && !w0) |=> $stable(cnt_crc));

  p_aln_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_aln && !w1) |=> cnt_aln == $past(cnt_aln) + CW'(1));
  p_aln_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_aln && !w1) |=> $stable(cnt_aln));

  p_dsc_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_dsc && !w2) |=> cnt_dsc == $past(cnt_dsc) + CW'(1));
  p_dsc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_dsc && !w2) |=> $stable(cnt_dsc));

  p_idle_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !(wr_en && !chan_en)) |=>
      ($stable(cnt_crc) && $stable(cnt_aln) && $stable(cnt_dsc)));

  p_locked_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && wr_en && !frame_end) |=>
      ($stable(cnt_crc) && $stable(cnt_aln) && $stable(cnt_dsc)));

  p_unused_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 2'd3 |-> rd_data == '0);
endmodule

bind rx_err_stats rx_err_stats_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .frame_end(frame_end),
  .addr_hit(addr_hit), .no_buf(no_buf), .overrun(overrun),
  .crc_bad(crc_bad), .dribble(dribble), .wr_en(wr_en), .wr_sel(wr_sel),
  .rd_sel(rd_sel), .rd_data(rd_data),
  .cnt_crc(cnt_crc), .cnt_aln(cnt_aln), .cnt_dsc(cnt_dsc)
);

// File: tb/rx_err_stats_tb.sv
module rx_err_stats_tb;
  localparam int CW = 32;
  localparam int NV = 12;
  // entry: {addr_hit, no_buf, overrun, crc_bad, dribble, exp_crc, exp_aln, exp_dsc}
  localparam logic [7:0] VEC [NV] = '{
    8'b10010_100, 8'b10001_010, 8'b10011_010, 8'b00010_000,
    8'b11010_001, 8'b10101_001, 8'b11000_001, 8'b10000_000,
    8'b00100_001, 8'b00001_000, 8'b11111_001, 8'b10010_100
  };

  logic clk = 0, rst_n = 0, chan_en = 1, frame_end = 0;
  logic addr_hit = 0, no_buf = 0, overrun = 0, crc_bad = 0, dribble = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0, rd_sel = 0;
  logic [CW-1:0] wr_data = 0, rd_data;
  int errors = 0, checks = 0;
  logic [CW-1:0] m_crc = 0, m_aln = 0, m_dsc = 0;

  always #5 clk = ~clk;

  rx_err_stats #(.CW(CW)) u_dut (.*);

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [CW-1:0] v);
    rd_sel = s;
    #1 v = rd_data;
  endtask

  task automatic chk_all(input string req, input logic [CW-1:0] c, input logic [CW-1:0] a, input logic [CW-1:0] d);
    logic [CW-1:0] v;
    rd(2'd0, v); chk({req, " crc"}, v, c);
    rd(2'd1, v); chk({req, " aln"}, v, a);
    rd(2'd2, v); chk({req, " dsc"}, v, d);
  endtask

  task automatic frame(input logic [4:0] f);
    @(negedge clk);
    {addr_hit, no_buf, overrun, crc_bad, dribble} = f;
    frame_end = 1;
    @(negedge clk);
    frame_end = 0;
    {addr_hit, no_buf, overrun, crc_bad, dribble} = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_all("R1 reset", '0, '0, '0);

    // R2 R3 R4: rule table
    for (int i = 0; i < NV; i++) begin
      frame(VEC[i][7:3]);
      m_crc += CW'(VEC[i][2]);
      m_aln += CW'(VEC[i][1]);
      m_dsc += CW'(VEC[i][0]);
      chk_all($sformatf("R2/R3/R4 vec%0d", i), m_crc, m_aln, m_dsc);
    end

    // R5: flags without a strobe
    @(negedge clk);
    {addr_hit, no_buf, overrun, crc_bad, dribble} = 5'b11111;
    repeat (3) @(negedge clk);
    {addr_hit, no_buf, overrun, crc_bad, dribble} = '0;
    chk_all("R5 no strobe", m_crc, m_aln, m_dsc);

    // R7: write while enabled is ignored
    chan_en = 1;
    wr(2'd0, 32'h1234); wr(2'd1, 32'h5678); wr(2'd2, 32'h9abc);
    chk_all("R7 locked", m_crc, m_aln, m_dsc);

    // R6: preset while disabled
    chan_en = 0;
    wr(2'd0, 32'h0000_000a); wr(2'd1, 32'h0000_000b); wr(2'd2, 32'h0000_000c);
    chk_all("R6 preset", 32'ha, 32'hb, 32'hc);
    wr(2'd3, 32'hdead_beef);
    chk_all("R6 sel3 no load", 32'ha, 32'hb, 32'hc);

    // R9: unused selector reads zero
    rd(2'd3, v); chk("R9 sel3 read", v, '0);

    // R8: wraparound
    wr(2'd0, '1); wr(2'd2, '1);
    frame(5'b10010);
    frame(5'b01000);
    chk_all("R8 wrap", '0, 32'hb, '0);

    // R10: write wins on collision, other counter still counts
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd1; wr_data = 32'h50;
    {addr_hit, no_buf, overrun, crc_bad, dribble} = 5'b10001;
    frame_end = 1;
    @(negedge clk);
    wr_en = 0; frame_end = 0;
    {addr_hit, no_buf, overrun, crc_bad, dribble} = '0;
    chk_all("R10 collision aln", '0, 32'h50, '0);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'd0; wr_data = 32'h7;
    {addr_hit, no_buf, overrun, crc_bad, dribble} = 5'b01001;
    frame_end = 1;
    @(negedge clk);
    wr_en = 0; frame_end = 0;
    {addr_hit, no_buf, overrun, crc_bad, dribble} = '0;
    chk_all("R10 other counts", 32'h7, 32'h50, 32'h1);

    // R1: reset after activity
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk_all("R1 re-reset", '0, '0, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule